// File: doc/BRIEF.md
# Halting Time-Division Die-Crossing Link

This block moves a wide parallel word across a narrow link between two dies by sending it in slices. A static ratio parameter selects 1, 2 or 4 slices per word. The sender takes a whole word on a rising edge of the slow user clock and puts one slice per fast link clock onto the link, lowest slice first. The receiver collects the slices into a shadow buffer and hands the complete word to the slow clock domain in a single step, so every output port is valid at the same time.

The slot select does not run freely. Once the last slice is on the link, the sender parks there with the strobe low and the slice held. When the receive side has sampled the complete word on a user clock edge, the select goes back to slot zero and the next word is taken on that same edge. The user clock must be the link clock divided by the ratio, with rising edges aligned. A small phase counter in the link domain marks the link edges that coincide with user edges. With a word always offered, the link delivers one word every two user cycles.

Top module: `tdm_die_link`

## Requirements
- R1: After a word is taken, `link_data` carries slice i (bits i*W to i*W+W-1) in the i-th link cycle that follows, slice 0 first, and `link_strobe` is high for exactly N consecutive link cycles per word.
- R2: While `rst` is high and after a user clock edge has occurred under reset, `rx_valid`, `link_strobe` and `rx_word` read zero and `tx_ready` reads one.
- R3: On a user cycle where `rx_valid` is high, `rx_word` equals the full word that was sent, with every slice in its original position. `rx_valid` never stays high for two user cycles in a row.
- R4: After the final slice has been sent, `link_data` keeps that slice and `link_strobe` stays low until the receiver has sampled the word.
- R5: A word is taken only on a user clock edge, and only when `tx_ready` was high before that edge. Values on `tx_word` while `tx_ready` is low have no effect on the delivered data.
- R6: A word taken on user edge L is presented on `rx_word` with `rx_valid` high after user edge L+2.
- R7: With a word always offered, `tx_ready` starts high after reset and then alternates low and high on each user cycle. The select returns to slot zero on the same user edge at which the receiver samples.
- R8: `user_clk` runs at the `link_clk` rate divided by N, with aligned rising edges. `rst` is synchronous and active high, is held across at least one user edge, and is released within the link cycle that follows a user edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| link_clk | input | 1 | Fast link clock |
| user_clk | input | 1 | Slow user clock, link clock divided by N, edges aligned |
| rst | input | 1 | Synchronous active-high reset |
| tx_word | input | N*W | Word offered by the sender |
| tx_ready | output | 1 | When high before a user edge, `tx_word` is taken on that edge |
| link_data | output | W | Slice currently on the link |
| link_strobe | output | 1 | High when `link_data` carries a new slice |
| rx_word | output | N*W | Rebuilt word, all slices together |
| rx_valid | output | 1 | `rx_word` holds a newly received word for this user cycle |

## Verification
The bench runs the ratios 1, 2 and 4 side by side. It sweeps walking-one, all-ones, all-zero and hashed words, so a slice placed at the wrong offset, or a slice from the previous word, shows up as a wrong bit on `rx_word`. Garbage is driven on `tx_word` in every cycle where `tx_ready` is low. A sender that loads outside slot zero would mix words, and the bench would see that as a data mismatch. It also checks the exact `tx_ready` and `rx_valid` cadence and the two-cycle latency, which catches a select that runs freely or releases early (wrong cadence) and a receiver that samples before the last slice has arrived (stale data). It also confirms that the parked slice stays on the link with the strobe low, which a design that kept the strobe high, or moved the select during the hold, would break.

// File: rtl/tdm_link_pkg.sv
package tdm_link_pkg;

    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,
        TX_SEND = 2'd1,
        TX_HOLD = 2'd2
    } tx_state_e;

    function automatic bit ratio_legal(input int n);
        return (n == 1) || (n == 2) || (n == 4);
    endfunction

    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/tdm_phase.sv
module tdm_phase #(
    parameter int N = 4
) (
    input  logic clk,
    input  logic rst,
    output logic user_edge
);
    localparam int PW = tdm_link_pkg::idx_w(N);
    localparam logic [PW-1:0] PH_LAST = PW'(N - 1);
    localparam logic [PW-1:0] PH_INIT = (N > 1) ? PW'(1) : '0;

    logic [PW-1:0] ph;

    always_ff @(posedge clk) begin
        if (rst)                ph <= PH_INIT;
        else if (ph == PH_LAST) ph <= '0;
        else                    ph <= ph + 1'b1;
    end

    assign user_edge = (ph == '0);

endmodule

// File: rtl/tdm_tx.sv
module tdm_tx #(
    parameter int N = 4,
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           user_edge,
    input  logic           rx_full,
    input  logic [N*W-1:0] tx_word,
    output logic           tx_ready,
    output logic [W-1:0]   link_data,
    output logic           link_strobe
);
    import tdm_link_pkg::*;

    localparam int SW = idx_w(N);
    localparam logic [SW-1:0] SEL_PENULT = SW'((N > 1) ? N - 2 : 0);

    tx_state_e             st;
    logic [SW-1:0]         sel;
    logic [SW-1:0]         nxt;
    logic [N-1:0][W-1:0]   held;
    logic [W-1:0]          lq;
    logic                  ls;
    logic                  take;

    assign nxt  = sel + 1'b1;
    assign take = user_edge && ((st == TX_IDLE) || ((st == TX_HOLD) && rx_full));

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= TX_IDLE;
            sel  <= '0;
            held <= '0;
            lq   <= '0;
            ls   <= 1'b0;
        end else begin
            ls <= 1'b0;
            if (take) begin
                held <= tx_word;
                sel  <= '0;
                lq   <= tx_word[W-1:0];
                ls   <= 1'b1;
                st   <= (N == 1) ? TX_HOLD : TX_SEND;
            end else if (st == TX_SEND) begin
                sel <= nxt;
                lq  <= held[nxt];
                ls  <= 1'b1;
                if (sel == SEL_PENULT) st <= TX_HOLD;
            end
        end
    end

    assign tx_ready    = (st == TX_IDLE) || ((st == TX_HOLD) && rx_full);
    assign link_data   = lq;
    assign link_strobe = ls;

    // R4: while parked, the final slice stays and no new strobe appears
    a_r4_hold_freeze: assert property (@(posedge clk) disable iff (rst)
        (st == TX_HOLD && !take) |=> (!link_strobe && $stable(link_data)));

    // R5: slot zero is only ever loaded on a link edge that was a user edge
    a_r5_load_on_user_edge: assert property (@(posedge clk) disable iff (rst)
        (link_strobe && sel == '0) |-> $past(user_edge));

endmodule

// File: rtl/tdm_rx.sv
module tdm_rx #(
    parameter int N = 4,
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           uclk,
    input  logic           rst,
    input  logic           user_edge,
    input  logic [W-1:0]   link_data,
    input  logic           link_strobe,
    output logic           rx_full,
    output logic [N*W-1:0] rx_word,
    output logic           rx_valid
);
    localparam int SW = tdm_link_pkg::idx_w(N);
    localparam logic [SW-1:0] SLOT_LAST = SW'(N - 1);

    logic [N-1:0][W-1:0] shadow;
    logic [SW-1:0]       slot;
    logic                full_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow <= '0;
            slot   <= '0;
            full_q <= 1'b0;
        end else begin
            if (full_q && user_edge) full_q <= 1'b0;
            if (link_strobe) begin
                shadow[slot] <= link_data;
                if (slot == SLOT_LAST) begin
                    slot   <= '0;
                    full_q <= 1'b1;
                end else begin
                    slot <= slot + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge uclk) begin
        if (rst) begin
            rx_word  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= full_q;
            if (full_q) rx_word <= shadow;
        end
    end

    assign rx_full = full_q;

    // R3: the last slice of a word always completes the shadow buffer
    a_r3_last_slice_fills: assert property (@(posedge clk) disable iff (rst)
        (link_strobe && slot == SLOT_LAST) |=> full_q);

    // R3: a delivered word is presented for one user cycle only
    a_r3_single_valid: assert property (@(posedge uclk) disable iff (rst)
        rx_valid |=> !rx_valid);

endmodule

// File: rtl/tdm_die_link.sv
module tdm_die_link #(
    parameter int W = 8,
    parameter int N = 4
) (
    input  logic           link_clk,
    input  logic           user_clk,
    input  logic           rst,
    input  logic [N*W-1:0] tx_word,
    output logic           tx_ready,
    output logic [W-1:0]   link_data,
    output logic           link_strobe,
    output logic [N*W-1:0] rx_word,
    output logic           rx_valid
);
    if (!tdm_link_pkg::ratio_legal(N)) begin : g_bad_ratio
        initial $fatal(1, "tdm_die_link: ratio N must be 1, 2 or 4");
    end

    logic user_edge;
    logic rx_full;

    tdm_phase #(.N(N)) u_phase (
        .clk       (link_clk),
        .rst       (rst),
        .user_edge (user_edge)
    );

    tdm_tx #(.N(N), .W(W)) u_tx (
        .clk         (link_clk),
        .rst         (rst),
        .user_edge   (user_edge),
        .rx_full     (rx_full),
        .tx_word     (tx_word),
        .tx_ready    (tx_ready),
        .link_data   (link_data),
        .link_strobe (link_strobe)
    );

    tdm_rx #(.N(N), .W(W)) u_rx (
        .clk         (link_clk),
        .uclk        (user_clk),
        .rst         (rst),
        .user_edge   (user_edge),
        .link_data   (link_data),
        .link_strobe (link_strobe),
        .rx_full     (rx_full),
        .rx_word     (rx_word),
        .rx_valid    (rx_valid)
    );

    // R7: the sender is only offered a new word once the receiver holds the old one
    a_r7_ready_needs_full: assert property (@(posedge link_clk) disable iff (rst)
        (tx_ready && $past(link_strobe)) |-> rx_full);

endmodule

// File: tb/tdm_die_link_bench.sv
module tdm_die_link_lane #(
    parameter int N = 4,
    parameter int W = 4
) (
    input  logic link_clk,
    input  logic user_clk,
    input  logic rst,
    input  logic fin,
    output int   n_run,
    output int   n_fail,
    output int   n_got
);
    localparam int TW = N * W;

    logic [TW-1:0] tx_word;
    logic          tx_ready;
    logic [W-1:0]  link_data;
    logic          link_strobe;
    logic [TW-1:0] rx_word;
    logic          rx_valid;

    int runs = 0;
    int fails = 0;
    int got = 0;
    assign n_run  = runs;
    assign n_fail = fails;
    assign n_got  = got;

    tdm_die_link #(.W(W), .N(N)) u_tdm_die_link (
        .link_clk    (link_clk),
        .user_clk    (user_clk),
        .rst         (rst),
        .tx_word     (tx_word),
        .tx_ready    (tx_ready),
        .link_data   (link_data),
        .link_strobe (link_strobe),
        .rx_word     (rx_word),
        .rx_valid    (rx_valid)
    );

    function automatic logic [TW-1:0] pat(input int k);
        logic [63:0] m;
        if (k < TW)      return TW'(1) << k;
        if (k == TW)     return '1;
        if (k == TW + 1) return '0;
        m = 64'(k) * 64'h9E37_79B9_7F4A_7C15;
        return m[40 +: TW];
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        runs++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s (ratio %0d): actual %0h expected %0h", req, N, act, exp);
        end
    endtask

    // user-domain driver and receiver checks
    initial begin
        int pe, k, rk;
        logic took, l0, l1, l2;
        logic [TW-1:0] w;
        tx_word = '0;
        pe = 0; k = 0; rk = 0; took = 0; l0 = 0; l1 = 0; l2 = 0;
        @(posedge user_clk);
        @(negedge user_clk);
        if (rst) begin
            // R2 and R8: reset state seen after a user edge under reset
            chk("R2 rx_valid", 64'(rx_valid), 64'd0);
            chk("R2 tx_ready", 64'(tx_ready), 64'd1);
            chk("R2 link_strobe", 64'(link_strobe), 64'd0);
            chk("R8 rx_word", 64'(rx_word), 64'd0);
        end
        wait (!rst);
        forever begin
            @(negedge user_clk);
            l2 = l1; l1 = l0; l0 = took;
            if (l0) k++;
            // R7: ready cadence, R5: loads only where ready was seen
            chk("R7 tx_ready", 64'(tx_ready), (pe == 0) ? 64'd1 : 64'(!l0));
            // R6: latency of two user edges
            chk("R6 rx_valid", 64'(rx_valid), 64'(l2));
            if (rx_valid) begin
                w = pat(rk);
                chk("R3 rx_word", 64'(rx_word), 64'(w));
                rk++;
                got = rk;
            end
            took = tx_ready;
            // R5: garbage while not ready must be ignored
            tx_word = tx_ready ? pat(k) : (~pat(k) ^ TW'(pe * 7));
            pe++;
        end
    end

    // link-domain slice order and hold checks
    initial begin
        int lw, lj, run;
        logic [TW-1:0] w;
        lw = 0; lj = 0; run = 0;
        wait (!rst);
        forever begin
            @(negedge link_clk);
            if (link_strobe) begin
                w = pat(lw);
                chk("R1 slice", 64'(link_data), 64'(w[lj*W +: W]));
                run++;
                lj++;
                if (lj == N) begin lj = 0; lw++; end
            end else begin
                if (run != 0) begin
                    chk("R1 strobe run", 64'(run), 64'(N));
                    run = 0;
                end
                if (lw > 0) begin
                    w = pat(lw - 1);
                    chk("R4 parked slice", 64'(link_data), 64'(w[(N-1)*W +: W]));
                end
            end
        end
    end

    initial begin
        @(posedge fin);
        chk("R3 words delivered", 64'(got > 20), 64'd1);
    end

endmodule

module tdm_die_link_bench;
    logic link_clk = 1'b0;
    logic uclk2 = 1'b0;
    logic uclk4 = 1'b0;
    logic rst = 1'b1;
    logic fin = 1'b0;
    int   h = 0;

    int r1, r2, r4, f1, f2, f4, g1, g2, g4;

    // 50 MHz link clock; user clocks share rising edges with it
    initial begin
        forever begin
            #10;
            h++;
            link_clk = (h % 2) == 0;
            uclk2    = (h % 4) >= 2;
            uclk4    = ((h % 8) >= 2) && ((h % 8) <= 5);
        end
    end

    tdm_die_link_lane #(.N(1), .W(4)) u_lane1 (
        .link_clk (link_clk), .user_clk (link_clk), .rst (rst), .fin (fin),
        .n_run (r1), .n_fail (f1), .n_got (g1));
    tdm_die_link_lane #(.N(2), .W(4)) u_lane2 (
        .link_clk (link_clk), .user_clk (uclk2), .rst (rst), .fin (fin),
        .n_run (r2), .n_fail (f2), .n_got (g2));
    tdm_die_link_lane #(.N(4), .W(4)) u_tdm_die_link (
        .link_clk (link_clk), .user_clk (uclk4), .rst (rst), .fin (fin),
        .n_run (r4), .n_fail (f4), .n_got (g4));

    initial begin
        int last, still, wd;
        last = 0; still = 0; wd = 0;
        repeat (4) @(posedge uclk4);
        #1 rst = 1'b0;
        for (int c = 0; c < 3000; c++) begin
            @(posedge link_clk);
            if (g1 + g2 + g4 != last) begin
                last  = g1 + g2 + g4;
                still = 0;
            end else begin
                still++;
            end
            if (still > 200) begin
                wd = 1;
                $display("FAIL R6 watchdog: actual no progress expected delivery");
                break;
            end
        end
        fin = 1'b1;
        repeat (2) @(posedge link_clk);
        #1;
        $display("[TB] %0d tests run, %0d failed", r1 + r2 + r4 + 1, f1 + f2 + f4 + wd);
        $finish;
    end

endmodule